// File: doc/BRIEF.md
# Comparator Interrupt Edge Selector

This block is the digital half of an analog comparator's control and status byte. The comparator's raw output comes in without any clock relation. It passes through a two-stage synchronizer. The block then compares the synchronized level with a registered copy of the previous level and looks for one of three events: any change, a high-to-low change or a low-to-high change. A two-bit mode field picks the event. When the selected event occurs, an event flag is set. An interrupt request leaves the block while the flag, a local enable bit and a global interrupt enable are all high.

Software reaches the byte through a single-register bus. A write updates the enable and the mode field, and it clears the flag when bit 4 of the written data is one. The same byte reads back the synchronized comparator level, the flag, the enable and the mode. The unused and reserved positions read as zero. Asserting the acknowledge input also clears the flag. The block keeps detecting events while the enable is low, so the flag can be polled.

Changing the mode while the interrupt is enabled can produce a false event. For that reason the block raises a hazard strobe for every write that changes the mode while the enable bit is set.

Top module: `cmp_irq_sel`

## Requirements
- R1: `irq_o` is high exactly when the flag (bit 4), the enable (bit 3) and `gie_i` are all one. It follows them combinationally.
- R2: Mode bits 1:0 select the event. Code 00 means any change of the synchronized level, 10 a change from 1 to 0, and 11 a change from 0 to 1. A change on `cmp_raw_i` before clock edge k appears in bit 5 after edge k+1. A matching event sets the flag at edge k+2.
- R3: With mode 01, no change of the comparator level sets the flag.
- R4: Bits 7, 6 and 2 of `reg_rdata_o` always read zero, whatever is written to them.
- R5: A write with data bit 4 = 1 clears the flag. A write with data bit 4 = 0 leaves the flag unchanged. Every write loads bit 3 into the enable and bits 1:0 into the mode.
- R6: When `irq_ack_i` is high at a clock edge, the flag clears at that edge.
- R7: If a flag-setting event and a clear (by write or by acknowledge) fall on the same edge, the flag ends up set.
- R8: `mode_hazard_o` is high in a cycle with `reg_we_i` = 1, the current enable = 1 and `reg_wdata_i[1:0]` different from the current mode. In every other cycle it is low.
- R9: Events set the flag while the enable is 0. `irq_o` stays low meanwhile.
- R10: After reset, `reg_rdata_o` reads 0x00 and `irq_o` and `mode_hazard_o` are low.
- R11: Bit 5 of `reg_rdata_o` returns the synchronized comparator level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request |
| mode_hazard_o | output | 1 | Strobe for a mode change written while enabled |

## Verification
The comparator input is driven through a full low-high-low cycle in each of the four mode codes. Because each mode sees both directions of change, the test separates a toggle detector from a single-edge detector, a rising detector from a falling one, and the reserved code from all of them. Clears are placed on the exact edge where an event lands, to check the set-wins priority. The global and local enables are then swept with a pending flag, which shows that request gating is separate from detection. A random phase mixes input changes, acknowledges and writes. It checks every cycle against a behavioural model, so corner timing such as a change arriving during a mode write is also covered.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned MODE_LSB  = 0;
  localparam int unsigned RSVD_BIT  = 2;
  localparam int unsigned EN_BIT    = 3;
  localparam int unsigned FLAG_BIT  = 4;
  localparam int unsigned LVL_BIT   = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= 1'b0;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= 1'b0;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  edge_mode_e mode_i,
  output logic       event_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      MODE_ANY:  event_o = rise | fall;
      MODE_FALL: event_o = fall;
      MODE_RISE: event_o = rise;
      default:   event_o = 1'b0; // reserved code
    endcase
  end
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             event_i,
  input  logic             ack_i,
  output logic             flag_o,
  output logic             en_o,
  output edge_mode_e       mode_o,
  output logic             hazard_o
);
  logic       flag_q, en_q;
  edge_mode_e mode_q;
  logic       clr;

  assign clr = ack_i | (we_i & wdata_i[FLAG_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= MODE_ANY;
    end else begin
      // set has priority over any clear
      if (event_i)  flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (we_i) begin
        en_q   <= wdata_i[EN_BIT];
        mode_q <= edge_mode_e'(wdata_i[MODE_LSB +: MODE_W]);
      end
    end
  end

  assign hazard_o = we_i & en_q & (wdata_i[MODE_LSB +: MODE_W] != mode_q);
  assign flag_o   = flag_q;
  assign en_o     = en_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/cmp_irq_sel.sv
module cmp_irq_sel
  import cmp_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             mode_hazard_o
);
  logic       lvl_s, evt, flag, en;
  edge_mode_e mode;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (lvl_s)
  );

  cmp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_s),
    .mode_i (mode),
    .event_o(evt)
  );

  cmp_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .event_i (evt),
    .ack_i   (irq_ack_i),
    .flag_o  (flag),
    .en_o    (en),
    .mode_o  (mode),
    .hazard_o(mode_hazard_o)
  );

  always_comb begin
    reg_rdata_o                       = '0;
    reg_rdata_o[LVL_BIT]              = lvl_s;
    reg_rdata_o[FLAG_BIT]             = flag;
    reg_rdata_o[EN_BIT]               = en;
    reg_rdata_o[MODE_LSB +: MODE_W]   = mode;
  end

  assign irq_o = flag & en & gie_i;
endmodule

// File: rtl/cmp_irq_sel_chk.sv
module cmp_irq_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gie_i,
  input logic       irq_ack_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       mode_hazard_o
);
  p_irq_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && reg_rdata_o[3] && reg_rdata_o[4]));

  // flag rises only after a level change two samples back
  p_flag_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[4]) |-> ($past(reg_rdata_o[5]) != $past(reg_rdata_o[5], 2)));

  p_rsvd_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[4]) |-> ($past(reg_rdata_o[1:0]) != 2'b01));

  p_rsvd_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[7:6] == 2'b00) && !reg_rdata_o[2]);

  p_w1c_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[4] && (reg_rdata_o[5] == $past(reg_rdata_o[5])))
      |=> !reg_rdata_o[4]);

  p_ack_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && (reg_rdata_o[5] == $past(reg_rdata_o[5]))) |=> !reg_rdata_o[4]);

  p_hazard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_hazard_o |-> (reg_we_i && reg_rdata_o[3]
                       && (reg_wdata_i[1:0] != reg_rdata_o[1:0])));
endmodule

bind cmp_irq_sel cmp_irq_sel_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gie_i        (gie_i),
  .irq_ack_i    (irq_ack_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .irq_o        (irq_o),
  .mode_hazard_o(mode_hazard_o)
);

// File: tb/cmp_irq_sel_bench.sv
module cmp_irq_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0, gie = 1'b0, ack = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, hazard;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk; // 200 MHz

  cmp_irq_sel u_cmp_irq_sel (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw), .gie_i(gie),
    .irq_ack_i(ack), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .mode_hazard_o(hazard)
  );

  // behavioural reference
  bit sync_q[$] = '{0, 0};
  bit m_prev = 0, m_flag = 0, m_en = 0;
  bit [1:0] m_mode = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q = '{0, 0}; m_prev = 0; m_flag = 0; m_en = 0; m_mode = 0;
    end else begin
      bit lvl, ev;
      lvl = sync_q[1];
      ev = (m_mode == 2'd0 && lvl != m_prev) ||
           (m_mode == 2'd2 && m_prev && !lvl) ||
           (m_mode == 2'd3 && !m_prev && lvl);
      if (ev) m_flag = 1;
      else if (ack || (we && wdata[4])) m_flag = 0;
      if (we) begin m_en = wdata[3]; m_mode = wdata[1:0]; end
      m_prev = lvl;
      void'(sync_q.pop_back());
      sync_q.push_front(raw);
    end
  end

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h @%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, 1 ns after the drive point
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      chk(rdata, {2'b00, sync_q[1], m_flag, m_en, 1'b0, m_mode}, "R2/R11 model rdata");
      chk({7'd0, irq}, {7'd0, m_flag & m_en & gie}, "R1 model irq");
      chk({7'd0, hazard}, {7'd0, we & m_en & (wdata[1:0] != m_mode)}, "R8 model hazard");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d; tick(1); we = 1'b0; wdata = 8'h00;
  endtask

  task automatic pulse_raw(input logic v);
    raw = v; tick(4);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    chk(rdata, 8'h00, "R10 reset rdata");
    chk({6'd0, irq, hazard}, 8'h00, "R10 reset irq/hazard");

    // toggle mode, enable off: polled flag
    pulse_raw(1);
    chk(rdata, 8'h30, "R9 R2 R11 toggle rise sets flag, disabled");
    chk({7'd0, irq}, 8'h00, "R9 no irq when disabled");
    wr(8'h10);
    chk(rdata, 8'h20, "R5 w1c clears flag");
    pulse_raw(0);
    chk(rdata[4], 1'b1, "R2 toggle fall sets flag");
    wr(8'h00);
    chk(rdata[4], 1'b1, "R5 write 0 keeps flag");
    wr(8'h12);
    chk(rdata, 8'h02, "R5 clear and load fall mode");

    // falling mode
    pulse_raw(1);
    chk(rdata[4], 1'b0, "R2 fall mode ignores rise");
    pulse_raw(0);
    chk(rdata[4], 1'b1, "R2 fall mode catches fall");
    wr(8'h13);
    // rising mode
    pulse_raw(1);
    chk(rdata, 8'h33, "R2 rise mode catches rise");
    wr(8'h13);
    pulse_raw(0);
    chk(rdata, 8'h03, "R2 rise mode ignores fall");

    // reserved mode
    wr(8'h01);
    pulse_raw(1); pulse_raw(0);
    chk(rdata, 8'h01, "R3 reserved mode never sets flag");

    // reserved bits
    wr(8'hE4);
    chk(rdata & 8'hC4, 8'h00, "R4 reserved bits read zero");

    // gating, ack
    wr(8'h08); // enable, toggle mode
    pulse_raw(1);
    chk({7'd0, irq}, 8'h00, "R1 no irq without gie");
    gie = 1'b1; tick(1);
    chk({7'd0, irq}, 8'h01, "R1 irq with flag, enable, gie");
    ack = 1'b1; tick(1); ack = 1'b0;
    chk({6'd0, rdata[4], irq}, 8'h00, "R6 ack clears flag");

    // set wins over ack on the same edge
    wr(8'h18); pulse_raw(0);   // flag=1
    raw = 1'b1; tick(2); ack = 1'b1; tick(1); ack = 1'b0;
    chk(rdata[4], 1'b1, "R7 event beats ack");
    raw = 1'b0; tick(2); we = 1'b1; wdata = 8'h18; tick(1); we = 1'b0; wdata = 0;
    chk(rdata[4], 1'b1, "R7 event beats w1c");

    // hazard strobe
    we = 1'b1; wdata = 8'h0B; #1;
    chk({7'd0, hazard}, 8'h01, "R8 mode change while enabled");
    tick(1); we = 1'b1; wdata = 8'h0B; #1;
    chk({7'd0, hazard}, 8'h00, "R8 same mode no hazard");
    tick(1); we = 1'b1; wdata = 8'h02; tick(1); we = 1'b1; wdata = 8'h03; #1;
    chk({7'd0, hazard}, 8'h00, "R8 no hazard when disabled");
    tick(1); we = 1'b0; wdata = 0;

    // random phase, model-checked
    for (int i = 0; i < 600; i++) begin
      raw = $urandom_range(0, 3) == 0 ? ~raw : raw;
      gie = $urandom_range(0, 1);
      ack = $urandom_range(0, 9) == 0;
      we  = $urandom_range(0, 7) == 0;
      wdata = 8'($urandom);
      tick(1);
    end
    ack = 0; we = 0;
    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule